// File: doc/BRIEF.md
# Dual Event Counter with Duration Mode

This block keeps two 40-bit event counters for a processor core. Each counter has a 9-bit function word. The low six bits pick one of 64 event codes. The top three bits are flags: a duration flag and two privilege enables, one for user mode and one for kernel mode. Every cycle the core drives two vectors. The pulse vector has one bit per code and marks an occurrence of that event. The level vector has one bit per code and marks that the event is in progress. A counter with the duration flag clear follows the pulse bit of its code. A counter with the duration flag set follows the level bit of its code, so it counts the cycles spent in that event. A counter increments only when the enable for the current privilege mode is set.

A small write port programs either function word or loads either counter directly. A function write is accepted only when it names a defined event code. An accepted function write also clears its counter. A rejected function write changes nothing and raises an error strobe. A read request takes one snapshot of both counters and both function words on the same clock edge, so the two counter values belong to the same instant.

Top module: `dual_evt_counter`

## Requirements
- R1: After reset both counters read 0, both function words read 0, and `wr_err` and `rd_valid` are low.
- R2: With function bit 8 clear, a counter adds one in each cycle in which `evt_pulse[code]` is high and counting is allowed. The level vector and all other codes have no effect on it.
- R3: With function bit 8 set, a counter adds one in each cycle in which `evt_level[code]` is high and counting is allowed. The pulse vector has no effect on it.
- R4: Counting is allowed when `mode_user`=1 and bit 7 is set, or when `mode_user`=0 and bit 6 is set. With bits 7 and 6 both clear a counter never increments.
- R5: A write with `wr_addr`=0 (counter 0) or 1 (counter 1) and a defined code in `wr_data[5:0]` stores `wr_data[8:0]` as the function word and clears that counter at the same edge.
- R6: The defined codes are 0x00–0x0F, 0x12–0x1F and 0x22–0x29. A function write with any other code leaves both function words and both counters unchanged. One cycle later it raises `wr_err` for exactly one cycle.
- R7: A write with `wr_addr`=2 (counter 0) or 3 (counter 1) loads `wr_data` into that counter. A load takes precedence over an event in the same cycle.
- R8: A counter wraps from 2^40−1 to 0 with no other effect.
- R9: `rd_en` captures both counters and both function words at one edge. `rd_valid` is high in the following cycle only, and the two counter values in the snapshot are coherent.
- R10: A write to one counter's function word or value leaves the other counter's state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_user | input | 1 | 1 = user mode, 0 = kernel mode |
| evt_pulse | input | 64 | One occurrence bit per event code |
| evt_level | input | 64 | One in-progress bit per event code |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0/1 function word of counter 0/1, 2/3 value of counter 0/1 |
| wr_data | input | 40 | Write data (function writes use bits 8:0) |
| rd_en | input | 1 | Snapshot request |
| rd_valid | output | 1 | Snapshot outputs updated |
| rd_cnt0 | output | 40 | Snapshot of counter 0 |
| rd_cnt1 | output | 40 | Snapshot of counter 1 |
| rd_fn0 | output | 9 | Snapshot of function word 0 |
| rd_fn1 | output | 9 | Snapshot of function word 1 |
| wr_err | output | 1 | Rejected function write strobe |

## Verification
The bench targets the undefined codes on both sides of each gap (0x10, 0x11, 0x20, 0x21, 0x2A) and the defined codes that border them (0x0F, 0x12, 0x22, 0x29). A decoder with an off-by-one boundary would reject a legal setting or accept an illegal one; either would show up in `wr_err` or in the function word read back. The bench drives the pulse and level vectors with different patterns on the same code. A design that picked the wrong vector would give a count that matches neither expected value. Further tests cover:
- a counter loaded close to 2^40, where wrong wrap handling would show up;
- a load in the same cycle as an event, where wrong precedence would show up;
- two counters running in lockstep, where an incoherent snapshot would break the fixed difference between the two values.

// File: rtl/evc_pkg.sv
package evc_pkg;

   // write address map
   typedef enum logic [1:0] {
      EVC_FN0  = 2'd0,
      EVC_FN1  = 2'd1,
      EVC_VAL0 = 2'd2,
      EVC_VAL1 = 2'd3
   } evc_addr_e;

   // number of flag bits on top of the code field
   localparam int EVC_FLAG_N = 3;

   // flag offsets relative to the code width
   localparam int EVC_KRN_OFS = 0;
   localparam int EVC_USR_OFS = 1;
   localparam int EVC_CYC_OFS = 2;

endpackage

// File: rtl/evc_code_check.sv
module evc_code_check #(
   parameter int CODE_W = 6
) (
   input  logic [CODE_W-1:0] code,
   output logic              defined
);
   // defined ranges, with undefined holes between them
   localparam int LO_A = 'h00;
   localparam int HI_A = 'h0f;
   localparam int LO_B = 'h12;
   localparam int HI_B = 'h1f;
   localparam int LO_C = 'h22;
   localparam int HI_C = 'h29;

   int code_i;

   always_comb begin
      code_i  = int'(code);
      defined = ((code_i >= LO_A) && (code_i <= HI_A)) ||
                ((code_i >= LO_B) && (code_i <= HI_B)) ||
                ((code_i >= LO_C) && (code_i <= HI_C));
   end
endmodule

// File: rtl/evc_counter.sv
module evc_counter
   import evc_pkg::*;
#(
   parameter  int CNT_W  = 40,
   parameter  int CODE_W = 6,
   localparam int EVT_N  = 1 << CODE_W,
   localparam int FN_W   = CODE_W + EVC_FLAG_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_user,
   input  logic [EVT_N-1:0] evt_pulse,
   input  logic [EVT_N-1:0] evt_level,
   input  logic             fn_wr,
   input  logic [FN_W-1:0]  fn_wdata,
   input  logic             val_wr,
   input  logic [CNT_W-1:0] val_wdata,
   output logic [FN_W-1:0]  fn_q,
   output logic [CNT_W-1:0] cnt_q
);
   localparam int CYC_B = CODE_W + EVC_CYC_OFS;
   localparam int USR_B = CODE_W + EVC_USR_OFS;
   localparam int KRN_B = CODE_W + EVC_KRN_OFS;

   logic [CODE_W-1:0] sel_code;
   logic              evt_hit;
   logic              mode_ok;
   logic              bump;

   always_comb begin
      sel_code = fn_q[CODE_W-1:0];
      evt_hit  = fn_q[CYC_B] ? evt_level[sel_code] : evt_pulse[sel_code];
      mode_ok  = mode_user ? fn_q[USR_B] : fn_q[KRN_B];
      bump     = evt_hit && mode_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fn_q  <= '0;
         cnt_q <= '0;
      end else if (fn_wr) begin
         fn_q  <= fn_wdata;
         cnt_q <= '0;
      end else if (val_wr) begin
         cnt_q <= val_wdata;
      end else if (bump) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/evc_snapshot.sv
module evc_snapshot #(
   parameter int CNT_W = 40,
   parameter int FN_W  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [CNT_W-1:0] cnt_a,
   input  logic [CNT_W-1:0] cnt_b,
   input  logic [FN_W-1:0]  fn_a,
   input  logic [FN_W-1:0]  fn_b,
   output logic             valid,
   output logic [CNT_W-1:0] snap_cnt_a,
   output logic [CNT_W-1:0] snap_cnt_b,
   output logic [FN_W-1:0]  snap_fn_a,
   output logic [FN_W-1:0]  snap_fn_b
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid      <= 1'b0;
         snap_cnt_a <= '0;
         snap_cnt_b <= '0;
         snap_fn_a  <= '0;
         snap_fn_b  <= '0;
      end else begin
         valid <= take;
         if (take) begin
            snap_cnt_a <= cnt_a;
            snap_cnt_b <= cnt_b;
            snap_fn_a  <= fn_a;
            snap_fn_b  <= fn_b;
         end
      end
   end
endmodule

// File: rtl/dual_evt_counter.sv
module dual_evt_counter
   import evc_pkg::*;
#(
   parameter  int CNT_W  = 40,
   parameter  int CODE_W = 6,
   localparam int EVT_N  = 1 << CODE_W,
   localparam int FN_W   = CODE_W + EVC_FLAG_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_user,
   input  logic [EVT_N-1:0] evt_pulse,
   input  logic [EVT_N-1:0] evt_level,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             rd_en,
   output logic             rd_valid,
   output logic [CNT_W-1:0] rd_cnt0,
   output logic [CNT_W-1:0] rd_cnt1,
   output logic [FN_W-1:0]  rd_fn0,
   output logic [FN_W-1:0]  rd_fn1,
   output logic             wr_err
);
   localparam int NUM_CTR = 2;

   if (CNT_W < FN_W || CNT_W > 64) begin : g_bad_cnt_w
      $error("dual_evt_counter: CNT_W must lie between FN_W and 64");
   end
   if (CODE_W < 6 || CODE_W > 8) begin : g_bad_code_w
      $error("dual_evt_counter: CODE_W must lie between 6 and 8");
   end

   logic                 fn_sel;
   logic                 code_ok;
   logic                 err_q;
   logic [FN_W-1:0]      fn_w  [NUM_CTR];
   logic [CNT_W-1:0]     cnt_w [NUM_CTR];
   logic [CNT_W-1:0]     cnt0_w, cnt1_w;
   logic [FN_W-1:0]      fn0_w, fn1_w;

   assign fn_sel = wr_en && (wr_addr == EVC_FN0 || wr_addr == EVC_FN1);

   evc_code_check #(.CODE_W(CODE_W)) i_code_check (
      .code    (wr_data[CODE_W-1:0]),
      .defined (code_ok)
   );

   for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
      logic fn_wr_g;
      logic val_wr_g;
      assign fn_wr_g  = fn_sel && code_ok && (wr_addr[0] == 1'(g));
      assign val_wr_g = wr_en && wr_addr[1] && (wr_addr[0] == 1'(g));

      evc_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W)) i_counter (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode_user (mode_user),
         .evt_pulse (evt_pulse),
         .evt_level (evt_level),
         .fn_wr     (fn_wr_g),
         .fn_wdata  (wr_data[FN_W-1:0]),
         .val_wr    (val_wr_g),
         .val_wdata (wr_data),
         .fn_q      (fn_w[g]),
         .cnt_q     (cnt_w[g])
      );
   end

   assign cnt0_w = cnt_w[0];
   assign cnt1_w = cnt_w[1];
   assign fn0_w  = fn_w[0];
   assign fn1_w  = fn_w[1];

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= fn_sel && !code_ok;
   end
   assign wr_err = err_q;

   evc_snapshot #(.CNT_W(CNT_W), .FN_W(FN_W)) i_snapshot (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (rd_en),
      .cnt_a      (cnt0_w),
      .cnt_b      (cnt1_w),
      .fn_a       (fn0_w),
      .fn_b       (fn1_w),
      .valid      (rd_valid),
      .snap_cnt_a (rd_cnt0),
      .snap_cnt_b (rd_cnt1),
      .snap_fn_a  (rd_fn0),
      .snap_fn_b  (rd_fn1)
   );
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
   parameter int CNT_W = 40,
   parameter int FN_W  = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic             rd_en,
   input logic             rd_valid,
   input logic             wr_err,
   input logic [FN_W-1:0]  fn0,
   input logic [FN_W-1:0]  fn1,
   input logic [CNT_W-1:0] cnt0,
   input logic [CNT_W-1:0] cnt1
);
   logic [CNT_W-1:0] prev0, prev1, step0, step1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev0 <= '0;
         prev1 <= '0;
      end else begin
         prev0 <= cnt0;
         prev1 <= cnt1;
      end
   end
   assign step0 = cnt0 - prev0;
   assign step1 = cnt1 - prev1;

   // R2 R8: without a write, a counter moves by at most one, modulo 2^CNT_W
   assert_step_le1_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> (step0 <= 1 && step1 <= 1));

   // R5: an accepted function write to counter 0 clears it
   assert_clear_fn0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(wr_addr) == 2'd0 && !wr_err) |-> cnt0 == '0);

   // R5: function words only change after a write
   assert_fn_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> ($stable(fn0) && $stable(fn1)));

   // R6: a rejected write leaves both function words as they were
   assert_reject_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> (fn0 == $past(fn0) && fn1 == $past(fn1)));

   // R6: the error strobe only follows a function write
   assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> ($past(wr_en) && !$past(wr_addr[1])));

   // R7: a value write to counter 1 loads it
   assert_load_ctr1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(wr_addr) == 2'd3) |-> cnt1 == $past(wr_data));

   // R9: rd_valid only follows a request
   assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_en));
endmodule

bind dual_evt_counter evc_checker #(.CNT_W(CNT_W), .FN_W(FN_W)) i_evc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .rd_en    (rd_en),
   .rd_valid (rd_valid),
   .wr_err   (wr_err),
   .fn0      (fn0_w),
   .fn1      (fn1_w),
   .cnt0     (cnt0_w),
   .cnt1     (cnt1_w)
);

// File: tb/test_dual_evt_counter.sv
`timescale 1ns/1ps
module test_dual_evt_counter;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        mode_user;
   logic [63:0] evt_pulse, evt_level;
   logic        wr_en;
   logic [1:0]  wr_addr;
   logic [39:0] wr_data;
   logic        rd_en;
   logic        rd_valid;
   logic [39:0] rd_cnt0, rd_cnt1;
   logic [8:0]  rd_fn0, rd_fn1;
   logic        wr_err;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   dual_evt_counter i_dual_evt_counter (
      .clk(clk), .rst_n(rst_n), .mode_user(mode_user),
      .evt_pulse(evt_pulse), .evt_level(evt_level),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_valid(rd_valid),
      .rd_cnt0(rd_cnt0), .rd_cnt1(rd_cnt1),
      .rd_fn0(rd_fn0), .rd_fn1(rd_fn1), .wr_err(wr_err)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] a, input logic [39:0] d, output logic err);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      err = wr_err;
   endtask

   task automatic do_read(output logic [39:0] c0, output logic [39:0] c1,
                          output logic [8:0] f0, output logic [8:0] f1);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(rd_valid == 1'b1, "R9 rd_valid", 64'(rd_valid), 64'd1);
      c0 = rd_cnt0; c1 = rd_cnt1; f0 = rd_fn0; f1 = rd_fn1;
   endtask

   task automatic t_reset();
      logic [39:0] c0, c1; logic [8:0] f0, f1;
      chk(rd_valid == 1'b0 && wr_err == 1'b0, "R1 strobes low", {rd_valid, wr_err}, 0);
      do_read(c0, c1, f0, f1);
      chk(c0 == 0 && c1 == 0, "R1 counters zero", {c0[31:0], c1[31:0]}, 0);
      chk(f0 == 0 && f1 == 0, "R1 functions zero", {f0, f1}, 0);
   endtask

   task automatic t_occurrence();
      logic e; logic [39:0] c0, c1; logic [8:0] f0, f1;
      do_write(2'd0, 40'h083, e);
      for (int i = 0; i < 9; i++) begin
         evt_level[3] = 1'b1;
         evt_pulse[4] = 1'b1;
         evt_pulse[3] = (i % 2 == 0);
         @(negedge clk);
      end
      evt_pulse = '0; evt_level = '0;
      do_read(c0, c1, f0, f1);
      chk(c0 == 5, "R2 pulse count", c0, 5);
      chk(c1 == 0, "R4 no flags no count", c1, 0);
   endtask

   task automatic t_duration();
      logic e; logic [39:0] c0, c1; logic [8:0] f0, f1;
      do_write(2'd1, 40'h192, e);
      for (int i = 0; i < 7; i++) begin
         evt_level[8'h12] = 1'b1;
         evt_pulse[8'h12] = (i < 2);
         @(negedge clk);
      end
      evt_level[8'h12] = 1'b0;
      for (int i = 0; i < 3; i++) begin
         evt_pulse[8'h12] = 1'b1;
         @(negedge clk);
      end
      evt_pulse = '0;
      do_read(c0, c1, f0, f1);
      chk(c1 == 7, "R3 level cycles", c1, 7);
      chk(c0 == 5, "R10 other counter kept", c0, 5);
      chk(f1 == 9'h192, "R5 function stored", f1, 9'h192);
   endtask

   task automatic t_mode();
      logic e; logic [39:0] c0, c1; logic [8:0] f0, f1;
      do_write(2'd0, 40'h045, e);
      mode_user = 1'b1;
      evt_pulse[5] = 1'b1;
      repeat (4) @(negedge clk);
      mode_user = 1'b0;
      repeat (3) @(negedge clk);
      evt_pulse = '0;
      do_read(c0, c1, f0, f1);
      chk(c0 == 3, "R4 kernel only", c0, 3);
      do_write(2'd0, 40'h005, e);
      evt_pulse[5] = 1'b1;
      repeat (2) @(negedge clk);
      mode_user = 1'b1;
      repeat (2) @(negedge clk);
      evt_pulse = '0;
      do_read(c0, c1, f0, f1);
      chk(c0 == 0, "R4 both enables clear", c0, 0);
   endtask

   task automatic t_clear();
      logic e; logic [39:0] c0, c1; logic [8:0] f0, f1;
      do_read(c0, c1, f0, f1);
      chk(c1 == 7, "R5 before clear", c1, 7);
      do_write(2'd1, 40'h0a2, e);
      do_read(c0, c1, f0, f1);
      chk(c1 == 0 && f1 == 9'h0a2, "R5 clear on function write", {f1, c1}, {9'h0a2, 40'd0});
   endtask

   task automatic t_reject();
      logic e; logic [39:0] c0, c1; logic [8:0] f0, f1;
      logic [5:0] bad [5] = '{6'h10, 6'h11, 6'h20, 6'h21, 6'h2a};
      logic [5:0] good [4] = '{6'h0f, 6'h12, 6'h22, 6'h29};
      do_write(2'd0, 40'h00c, e);
      do_write(2'd2, 40'd1234, e);
      for (int i = 0; i < 5; i++) begin
         do_write(2'd0, {31'd0, 3'b111, bad[i]}, e);
         chk(e == 1'b1, "R6 error strobe", 64'(e), 1);
         @(negedge clk);
         chk(wr_err == 1'b0, "R6 strobe one cycle", 64'(wr_err), 0);
      end
      do_read(c0, c1, f0, f1);
      chk(f0 == 9'h00c, "R6 function unchanged", f0, 9'h00c);
      chk(c0 == 1234, "R6 counter unchanged", c0, 1234);
      for (int i = 0; i < 4; i++) begin
         do_write(2'd1, {34'd0, good[i]}, e);
         chk(e == 1'b0, "R6 boundary code accepted", 64'(e), 0);
         do_read(c0, c1, f0, f1);
         chk(f1 == {3'b000, good[i]}, "R6 boundary code stored", f1, {3'b000, good[i]});
      end
   endtask

   task automatic t_load_wrap();
      logic e; logic [39:0] c0, c1; logic [8:0] f0, f1;
      do_write(2'd0, 40'h081, e);
      evt_pulse[1] = 1'b1;
      do_write(2'd2, 40'd100, e);
      evt_pulse = '0;
      do_read(c0, c1, f0, f1);
      chk(c0 == 100, "R7 load beats event", c0, 100);
      do_write(2'd1, 40'h080, e);
      do_write(2'd3, 40'hff_ffff_fffd, e);
      evt_pulse[0] = 1'b1;
      repeat (5) @(negedge clk);
      evt_pulse = '0;
      do_read(c0, c1, f0, f1);
      chk(c1 == 2, "R8 wrap modulo 2^40", c1, 2);
      chk(c0 == 100, "R10 load isolation", c0, 100);
   endtask

   task automatic t_coherent();
      logic e; logic [39:0] c0, c1; logic [8:0] f0, f1;
      evt_level[0] = 1'b1;
      do_write(2'd0, 40'h180, e);
      do_write(2'd1, 40'h180, e);
      repeat (3) @(negedge clk);
      do_read(c0, c1, f0, f1);
      chk(c0 == 4 && c1 == 3, "R9 snapshot pair", {c0[31:0], c1[31:0]}, {32'd4, 32'd3});
      do_read(c0, c1, f0, f1);
      chk(c0 == 5 && c1 == 4, "R9 snapshot pair again", {c0[31:0], c1[31:0]}, {32'd5, 32'd4});
      evt_level = '0;
      @(negedge clk);
      chk(rd_valid == 1'b0, "R9 rd_valid one cycle", 64'(rd_valid), 0);
   endtask

   initial begin
      rst_n = 1'b0; mode_user = 1'b1;
      evt_pulse = '0; evt_level = '0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_occurrence();
      t_duration();
      t_clear();
      t_mode();
      t_reject();
      t_load_wrap();
      t_coherent();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule